// File: doc/BRIEF.md
# Serial Flash Status Write-Guard

This block is the device-side controller for the status byte of a serial flash memory. It listens to a serial instruction stream (chip select, serial clock and a single data-in line). It keeps the write-enable latch, the protection-level bits and the status-write-disable bit, and it decides whether an incoming status write may take effect. The decision combines the latch with two protection modes. In the hardware-locked mode, a set status-write-disable bit together with a low write-protect pin freezes the status byte. In the software mode, any status write is honoured once the latch is set.

The controller also answers a side query from the array controller. Given an operation kind and a byte address, it reports whether a page program, a sector erase or a full-array erase is permitted under the current protection level. It runs on a fast system clock, synchronises the serial pins into that domain and acts on detected serial clock edges. The control state machine has seven states. IDLE waits for chip select. OPCODE collects eight instruction bits. ARMED holds a write-enable or write-disable until chip select rises. WDATA collects the eight status bits. WFULL waits for chip select to rise and commit. RDOUT streams the status byte out. SKIP swallows an unknown or over-long frame. The named transitions are: select (IDLE to OPCODE), decode (OPCODE to ARMED, WDATA, RDOUT or SKIP), data_full (WDATA to WFULL), overrun (ARMED or WFULL to SKIP on an extra clock), and deselect (any state to IDLE when chip select goes high, which commits from ARMED or WFULL).

Top module: `spi_status_guard`

## Requirements
- R1: After reset the status byte reads 00h: the status-write-disable bit, the protection bits and the write-enable latch are all 0.
- R2: Opcode 06h sets the write-enable latch and opcode 04h clears it. Either one takes effect only if chip select rises after exactly 8 serial clocks.
- R3: Opcode 01h followed by 8 data bits (MSB first, on the data-in line) writes data bit 7 into the status-write-disable bit and data bits 4..2 into the protection bits. It does so only if the write-enable latch is set, and a completed write clears the latch.
- R4: While the status-write-disable bit is 1 and wp_n is low, a status write is refused. The status byte, including the latch, is left unchanged.
- R5: While the status-write-disable bit is 0 (either wp_n level), or while it is 1 with wp_n high, a status write with the latch set is accepted.
- R6: A status-write frame whose chip select rises after any count of clocks other than 16 changes nothing.
- R7: Opcode 05h drives the status byte on dq1_out MSB first, one bit per serial clock, and repeats it for as long as chip select stays low. The layout is bit 7 status-write-disable, bits 6..5 zero, bits 4..2 protection level, bit 1 write-enable latch, bit 0 busy.
- R8: dq1_oe is 0 at all times except while a status read (05h) is streaming. In particular it stays 0 through a whole status-write frame.
- R9: For a protection level k from 1 to 7, the top 2^(k-1)/64 of the 2^ADDR_W-byte array is protected, so level 7 covers all of it. chk_op 01 (page program) and 10 (sector erase) give chk_ok = 1 only at an unprotected address.
- R10: chk_op 11 (full-array erase) gives chk_ok = 1 only when the protection level is 0. chk_op 00 always gives chk_ok = 0.
- R11: Status bit 0 follows the array_busy input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock; data-in is sampled on its rising edge |
| dq0 | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin; low together with the status-write-disable bit locks the status byte |
| array_busy | input | 1 | Busy flag from the array controller, shown as status bit 0 |
| chk_op | input | 2 | Query kind: 00 none, 01 page program, 10 sector erase, 11 full-array erase |
| chk_addr | input | ADDR_W (21) | Byte address of the query |
| chk_ok | output | 1 | Query permitted under the current protection level |
| dq1_out | output | 1 | Serial data out |
| dq1_oe | output | 1 | Output enable for dq1_out; 0 means high impedance |

## Verification
The serial pins pass through two synchroniser flops and one edge register, so a sampled bit or a chip-select rise acts on the state about three system clocks after the pin moves. Each serial half-period in the bench lasts four system clocks, and chip select stays high for eight before the next frame. A committed status write is therefore always settled before the read-back frame starts. For a read, dq1_out is sampled eight system clocks after the previous rising serial edge, just before the next rise, where the new bit is stable. The chk_ok answer is combinational on the query inputs and the stored protection level, so it is checked one system clock after the query is applied.

// File: rtl/spg_pkg.sv
package spg_pkg;

    localparam int BP_W = 3;

    localparam logic [7:0] OPC_WEL_SET = 8'h06;
    localparam logic [7:0] OPC_WEL_CLR = 8'h04;
    localparam logic [7:0] OPC_ST_WR   = 8'h01;
    localparam logic [7:0] OPC_ST_RD   = 8'h05;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ARMED,
        ST_WDATA,
        ST_WFULL,
        ST_RDOUT,
        ST_SKIP
    } ctrl_state_t;

    typedef enum logic [1:0] {
        CHK_NONE   = 2'b00,
        CHK_PAGE   = 2'b01,
        CHK_SECTOR = 2'b10,
        CHK_BULK   = 2'b11
    } chk_op_t;

endpackage

// File: rtl/spg_sync.sv
module spg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic dq0,
    input  logic wp_n,
    output logic cs_hi,
    output logic sck_rise,
    output logic dq0_s,
    output logic wp_s
);

    localparam int          LANES = 4;
    localparam logic [LANES-1:0] RST_V = 4'b1000;

    logic [LANES-1:0] pipe [STAGES];
    logic             sck_s;
    logic             sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_V;
            sck_d <= 1'b0;
        end else begin
            pipe[0] <= {cs_n, sck, dq0, wp_n};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            sck_d <= sck_s;
        end
    end

    assign cs_hi    = pipe[STAGES-1][3];
    assign sck_s    = pipe[STAGES-1][2];
    assign dq0_s    = pipe[STAGES-1][1];
    assign wp_s     = pipe[STAGES-1][0];
    assign sck_rise = sck_s & ~sck_d;

endmodule

// File: rtl/spg_ctrl.sv
module spg_ctrl
    import spg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_hi,
    input  logic            sck_rise,
    input  logic            dq0_s,
    input  logic            wp_s,
    input  logic            busy,
    output logic            srwd,
    output logic [BP_W-1:0] bp,
    output logic            wel,
    output logic            dq1_out,
    output logic            dq1_oe
);

    ctrl_state_t state, state_nx;
    logic [2:0]  bitcnt;
    logic [7:0]  shreg;
    logic [7:0]  outreg;
    logic [7:0]  status_byte;
    logic [7:0]  opcode_now;
    logic        hw_locked;

    assign status_byte = {srwd, 2'b00, bp, wel, busy};
    assign opcode_now  = {shreg[6:0], dq0_s};
    assign hw_locked   = srwd & ~wp_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (!cs_hi) state_nx = ST_OPCODE;
            ST_OPCODE: begin
                if (cs_hi) state_nx = ST_IDLE;
                else if (sck_rise && bitcnt == 3'd7) begin
                    if (opcode_now == OPC_WEL_SET || opcode_now == OPC_WEL_CLR)
                        state_nx = ST_ARMED;
                    else if (opcode_now == OPC_ST_WR)
                        state_nx = ST_WDATA;
                    else if (opcode_now == OPC_ST_RD)
                        state_nx = ST_RDOUT;
                    else
                        state_nx = ST_SKIP;
                end
            end
            ST_ARMED: begin
                if (cs_hi)         state_nx = ST_IDLE;
                else if (sck_rise) state_nx = ST_SKIP;
            end
            ST_WDATA: begin
                if (cs_hi) state_nx = ST_IDLE;
                else if (sck_rise && bitcnt == 3'd7) state_nx = ST_WFULL;
            end
            ST_WFULL: begin
                if (cs_hi)         state_nx = ST_IDLE;
                else if (sck_rise) state_nx = ST_SKIP;
            end
            ST_RDOUT:  if (cs_hi) state_nx = ST_IDLE;
            ST_SKIP:   if (cs_hi) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // shifting and status storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            outreg <= '0;
            srwd   <= 1'b0;
            bp     <= '0;
            wel    <= 1'b0;
        end else begin
            if (state == ST_IDLE) bitcnt <= '0;
            else if (sck_rise && (state == ST_OPCODE || state == ST_WDATA || state == ST_RDOUT))
                bitcnt <= bitcnt + 3'd1;

            if (sck_rise && (state == ST_OPCODE || state == ST_WDATA))
                shreg <= opcode_now;

            if (state == ST_OPCODE && state_nx == ST_RDOUT)
                outreg <= status_byte;
            else if (state == ST_RDOUT && sck_rise) begin
                if (bitcnt == 3'd7) outreg <= status_byte;
                else                outreg <= {outreg[6:0], 1'b0};
            end

            if (state == ST_ARMED && cs_hi) begin
                if (shreg == OPC_WEL_SET)      wel <= 1'b1;
                else if (shreg == OPC_WEL_CLR) wel <= 1'b0;
            end

            if (state == ST_WFULL && cs_hi && wel && !hw_locked) begin
                srwd <= shreg[7];
                bp   <= shreg[4:2];
                wel  <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        dq1_oe  = (state == ST_RDOUT);
        dq1_out = dq1_oe ? outreg[7] : 1'b0;
    end

    AST_HW_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (srwd && !wp_s) |=> ($stable(srwd) && $stable(bp))); // R4

    AST_WEL_GATES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wel |=> ($stable(srwd) && $stable(bp))); // R3

    AST_WRITE_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (srwd != $past(srwd) || bp != $past(bp)) |-> !wel); // R3

endmodule

// File: rtl/spg_region.sv
module spg_region
    import spg_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic [BP_W-1:0]   bp,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    output logic              ok
);

    localparam int LEVELS    = 1 << BP_W;
    localparam int FRAC_LOG2 = LEVELS - 2;

    logic [LEVELS-1:0] hit;
    logic              prot;

    assign hit[0] = 1'b0;

    for (genvar k = 1; k < LEVELS; k++) begin : g_lvl
        localparam int NB = FRAC_LOG2 + 1 - k;
        if (NB == 0) begin : g_all
            assign hit[k] = 1'b1;
        end else begin : g_top
            assign hit[k] = &addr[ADDR_W-1 -: NB];
        end
    end

    assign prot = hit[bp];

    always_comb begin
        unique case (chk_op_t'(op))
            CHK_NONE:   ok = 1'b0;
            CHK_PAGE:   ok = !prot;
            CHK_SECTOR: ok = !prot;
            CHK_BULK:   ok = (bp == '0);
            default:    ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
    import spg_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              dq0,
    input  logic              wp_n,
    input  logic              array_busy,
    input  logic [1:0]        chk_op,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_ok,
    output logic              dq1_out,
    output logic              dq1_oe
);

    logic            cs_hi, sck_rise, dq0_s, wp_s;
    logic            srwd, wel;
    logic [BP_W-1:0] bp;

    spg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .dq0      (dq0),
        .wp_n     (wp_n),
        .cs_hi    (cs_hi),
        .sck_rise (sck_rise),
        .dq0_s    (dq0_s),
        .wp_s     (wp_s)
    );

    spg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_hi    (cs_hi),
        .sck_rise (sck_rise),
        .dq0_s    (dq0_s),
        .wp_s     (wp_s),
        .busy     (array_busy),
        .srwd     (srwd),
        .bp       (bp),
        .wel      (wel),
        .dq1_out  (dq1_out),
        .dq1_oe   (dq1_oe)
    );

    spg_region #(.ADDR_W(ADDR_W)) u_region (
        .bp   (bp),
        .op   (chk_op),
        .addr (chk_addr),
        .ok   (chk_ok)
    );

    AST_DQ1_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !dq1_oe); // R8

    AST_BULK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_op == 2'b11 && bp != '0) |-> !chk_ok); // R10

    AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (bp == '1) |-> !chk_ok); // R9

    AST_NONE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_op == 2'b00) |-> !chk_ok); // R10

endmodule

// File: tb/tb_spi_status_guard.sv
module tb_spi_status_guard;

    localparam int ADDR_W = 21;
    localparam int SIZE   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1, sck = 1'b0, dq0 = 1'b0, wp_n = 1'b1;
    logic              array_busy = 1'b0;
    logic [1:0]        chk_op = 2'b00;
    logic [ADDR_W-1:0] chk_addr = '0;
    logic              chk_ok, dq1_out, dq1_oe;

    int  tests = 0, fails = 0;
    bit  done = 0;

    logic       m_srwd = 0, m_wel = 0;
    logic [2:0] m_bp = 0;

    always #10 clk = ~clk;

    spi_status_guard #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .dq0(dq0),
        .wp_n(wp_n), .array_busy(array_busy), .chk_op(chk_op),
        .chk_addr(chk_addr), .chk_ok(chk_ok), .dq1_out(dq1_out), .dq1_oe(dq1_oe)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [23:0] bits, input int n);
        cs_n = 1'b0;
        wait_n(4);
        for (int i = n - 1; i >= 0; i--) begin
            dq0 = bits[i];
            wait_n(4);
            sck = 1'b1;
            wait_n(4);
            sck = 1'b0;
        end
        wait_n(4);
        check("R8 oe low in non-read frame", dq1_oe, 1'b0);
        cs_n = 1'b1;
        wait_n(8);
    endtask

    task automatic read_status(output logic [15:0] v);
        cs_n = 1'b0;
        wait_n(4);
        for (int i = 7; i >= 0; i--) begin
            dq0 = OPC_RD[i];
            wait_n(4);
            sck = 1'b1;
            wait_n(4);
            sck = 1'b0;
        end
        for (int i = 15; i >= 0; i--) begin
            wait_n(4);
            check("R8 oe high while reading", dq1_oe, 1'b1);
            v[i] = dq1_out;
            sck = 1'b1;
            wait_n(4);
            sck = 1'b0;
        end
        wait_n(4);
        cs_n = 1'b1;
        wait_n(8);
        check("R8 oe low after read", dq1_oe, 1'b0);
    endtask

    localparam logic [7:0] OPC_RD = 8'h05;

    function automatic logic [7:0] model_byte();
        return {m_srwd, 2'b00, m_bp, m_wel, array_busy};
    endfunction

    task automatic expect_status(input string req);
        logic [15:0] v;
        read_status(v);
        check(req, v[15:8], model_byte());
        check("R7 repeated byte", v[7:0], model_byte());
    endtask

    task automatic wren();
        frame(24'h06, 8);
        m_wel = 1'b1;
    endtask

    task automatic wrsr(input logic [7:0] d);
        frame({16'h0, 8'h01} << 8 | 24'(d), 16);
        if (m_wel && !(m_srwd && !wp_n)) begin
            m_srwd = d[7];
            m_bp   = d[4:2];
            m_wel  = 1'b0;
        end
    endtask

    function automatic logic prot(input int k, input int a);
        if (k == 0) return 1'b0;
        return a >= SIZE - (SIZE >> (7 - k));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        check("R8 oe low in reset", dq1_oe, 1'b0);
        rst_n = 1'b1;
        wait_n(5);

        // R1 reset state
        expect_status("R1 reset status");

        // R2 latch set and clear
        wren();
        expect_status("R2 WREN sets latch");
        frame(24'h04, 8);
        m_wel = 1'b0;
        expect_status("R2 WRDI clears latch");
        frame({8'h06, 1'b1}, 9);
        expect_status("R2 WREN with 9 clocks ignored");
        wren();
        frame({8'h04, 1'b0}, 9);
        expect_status("R2 WRDI with 9 clocks ignored");

        // R6 wrong length status writes (latch is set)
        frame(24'({8'h01, 8'h9C}) >> 1, 15);
        expect_status("R6 15-clock write aborted");
        frame((24'({8'h01, 8'h9C}) << 1) | 24'd1, 17);
        expect_status("R6 17-clock write aborted");
        frame(24'h01, 8);
        expect_status("R6 8-clock write aborted");

        // R3 write without latch is refused
        frame(24'h04, 8);
        m_wel = 1'b0;
        wrsr(8'h1C);
        expect_status("R3 write without latch refused");
        wren();
        wrsr(8'h6B);
        expect_status("R3 write with latch, ignored bits masked");

        // R4/R5 sweep over SRWD, wp and latch
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < 2; w++) begin
                for (int e = 0; e < 2; e++) begin
                    wp_n = 1'b1;
                    wait_n(4);
                    wren();
                    wrsr({s[0], 2'b00, 3'b001, 2'b00});
                    expect_status("R5 setup");
                    wp_n = w[0];
                    wait_n(4);
                    if (e != 0) wren();
                    wrsr({~s[0], 2'b11, 3'b110, 2'b11});
                    if (s != 0 && w == 0)
                        expect_status("R4 hardware lock");
                    else
                        expect_status("R5 software mode");
                end
            end
        end
        wp_n = 1'b1;
        wait_n(4);

        // R11 busy bit
        array_busy = 1'b1;
        expect_status("R11 busy shown");
        array_busy = 1'b0;
        expect_status("R11 busy cleared");

        // R9/R10 region sweep
        for (int k = 0; k < 8; k++) begin
            wren();
            wrsr({1'b0, 2'b00, 3'(k), 2'b00});
            for (int n = 0; n < 7; n++) begin
                for (int d = 0; d < 2; d++) begin
                    int a;
                    a = SIZE - (SIZE >> n) - d;
                    if (a < 0) a = SIZE - 1;
                    chk_addr = ADDR_W'(a);
                    for (int op = 0; op < 4; op++) begin
                        logic exp;
                        chk_op = 2'(op);
                        wait_n(1);
                        case (op)
                            0: exp = 1'b0;
                            1, 2: exp = !prot(k, a);
                            default: exp = (k == 0);
                        endcase
                        if (op == 1 || op == 2) check("R9 region check", chk_ok, exp);
                        else                    check("R10 bulk and none", chk_ok, exp);
                    end
                end
            end
        end
        chk_op = 2'b00;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule